// File: doc/BRIEF.md
# Byte FIFO pair with threshold flags and timed flush

This block holds the byte queues that sit between a host register interface and a serial bus engine. The transmit queue is filled by the host through a data port and drained by the engine. The receive queue is filled by the engine and drained by the host. Each queue is 16 entries deep by default. The block reports empty, full and threshold-based level flags to the interrupt logic around it. A sticky overrun flag records host writes that reach a full transmit queue.

A control port carries two flush commands. Bit 7 empties the transmit queue and bit 8 empties the receive queue. Either or both may be set in one write. Each flush runs for a fixed number of cycles, four by default, and is sequenced by its own small state machine.

The flush state machine has three states:
- FL_IDLE goes to FL_WAIT when a control write sets the side's flush bit.
- FL_WAIT counts and goes to FL_CLEAR after FLUSH_CYCLES-1 cycles.
- FL_CLEAR resets the queue pointers and occupancy and returns to FL_IDLE.

The flush bit reads back as 1 in every state except FL_IDLE, so software polls it until it clears. While a side is flushing, every data access to that side is ignored.

Top module: `sfifo_pair`

## Requirements
- R1: After reset, both levels are 0 and both empty flags are 1. Full and overrun flags are 0, control readback is 0 and both data outputs are 0. Thresholds are 0, so TX nearly-empty and RX nearly-full both read 1.
- R2: Each queue is first-in first-out. The head byte is visible on its data output (eng_tx_data for TX, host_rx_data for RX) before the pop, and each accepted push or pop moves the level by one on the following clock edge.
- R3: A host write while TX is full is dropped and leaves the stored bytes intact. It sets tx_overrun, which stays set until ovr_clr is pulsed.
- R4: A control write with bit 7 set makes control readback bit 7 read 1 for exactly FLUSH_CYCLES (4) cycles after the write edge. The TX level keeps its value until the last of those cycles and is 0 once the bit reads 0.
- R5: Bit 8 flushes only RX and bit 7 flushes only TX. Both bits in one write flush both queues together. A control write with neither bit set has no effect.
- R6: While a side is flushing, host writes, host reads, engine pushes and engine pops on that side are ignored. Its data output reads 0 and no overrun is recorded.
- R7: tx_nearly_empty is 1 exactly when the TX level is less than or equal to the 4-bit TX threshold written through thr_tx_wr.
- R8: rx_nearly_full is 1 exactly when the RX level is greater than or equal to the 4-bit RX threshold written through thr_rx_wr. The largest threshold is 15.
- R9: Full is 1 exactly at level 16 and empty is 1 exactly at level 0 for each queue. An engine push to a full RX queue is dropped.
- R10: A host read of an empty RX queue returns 0 and leaves the level at 0. An engine pop of an empty TX queue leaves the level at 0, and a later write is read back correctly.
- R11: A simultaneous push and pop on a queue that is neither empty nor full leaves the level unchanged and keeps the byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 9 | Control write data; bit 7 flushes TX, bit 8 flushes RX |
| ctrl_rdata | output | 9 | Control readback; bits 7 and 8 show flush in progress |
| thr_tx_wr | input | 1 | Write strobe for the TX threshold |
| thr_rx_wr | input | 1 | Write strobe for the RX threshold |
| thr_wdata | input | 4 | Threshold value |
| host_tx_wr | input | 1 | Host pushes a byte into TX |
| host_tx_data | input | 8 | Byte pushed into TX |
| host_rx_rd | input | 1 | Host pops a byte from RX |
| host_rx_data | output | 8 | RX head byte, 0 when empty or flushing |
| eng_tx_pop | input | 1 | Engine pops a byte from TX |
| eng_tx_data | output | 8 | TX head byte, 0 when empty or flushing |
| eng_rx_push | input | 1 | Engine pushes a byte into RX |
| eng_rx_data | input | 8 | Byte pushed into RX |
| ovr_clr | input | 1 | Clears the TX overrun flag |
| tx_level | output | 5 | TX occupancy |
| rx_level | output | 5 | RX occupancy |
| tx_empty | output | 1 | TX level is 0 |
| tx_nearly_empty | output | 1 | TX level at or below TX threshold |
| tx_full | output | 1 | TX level is 16 |
| tx_overrun | output | 1 | Sticky: a write reached a full TX queue |
| rx_empty | output | 1 | RX level is 0 |
| rx_nearly_full | output | 1 | RX level at or above RX threshold |
| rx_full | output | 1 | RX level is 16 |

## Verification
Every push, pop, threshold write and overrun update takes effect at the first clock edge after the strobe. Levels and flags are combinational from the registered state, so they are due in the cycle right after that edge. A flush bit reads 1 in the cycle after its control write edge and clears four edges later, at the same edge that empties the queue. The bench drives inputs just after a falling edge and samples just after the next falling edge, so each sample lands in the cycle in which a result is due. The flush checks sample once in each of the four busy cycles and then in the first idle cycle.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_WAIT  = 2'd1,
        FL_CLEAR = 2'd2
    } flush_state_t;

    localparam int CTRL_W       = 9;
    localparam int TX_FLUSH_BIT = 7;
    localparam int RX_FLUSH_BIT = 8;
endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       wr_en,
    input  logic [WIDTH-1:0]           wr_data,
    input  logic                       rd_en,
    output logic [WIDTH-1:0]           rd_data,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic             wr_ok, rd_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign wr_ok = wr_en && !full && !clr;
    assign rd_ok = rd_en && !empty && !clr;
    assign rd_data = empty ? '0 : mem[rptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wptr <= bump(wptr);
            if (rd_ok) rptr <= bump(rptr);
            unique case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wr_data;
    end

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en && !clr) |=> full);

    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_en) |=> empty);
endmodule

// File: rtl/sfifo_flush_fsm.sv
module sfifo_flush_fsm
    import sfifo_pkg::*;
#(
    parameter int FLUSH_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic clr
);
    localparam int CNT_W = (FLUSH_CYCLES > 2) ? $clog2(FLUSH_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FLUSH_CYCLES - 2);

    flush_state_t     state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FL_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            FL_IDLE: begin
                if (start) begin
                    state_n = FL_WAIT;
                    cnt_n   = '0;
                end
            end
            FL_WAIT: begin
                if (cnt == LAST) state_n = FL_CLEAR;
                else             cnt_n   = cnt + 1'b1;
            end
            FL_CLEAR: state_n = FL_IDLE;
            default:  state_n = FL_IDLE;
        endcase
    end

    always_comb begin
        busy = 1'b0;
        clr  = 1'b0;
        unique case (state)
            FL_IDLE:  busy = 1'b0;
            FL_WAIT:  busy = 1'b1;
            FL_CLEAR: begin
                busy = 1'b1;
                clr  = 1'b1;
            end
            default:  busy = 1'b0;
        endcase
    end

    assert_start_sets_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == FL_IDLE) |=> busy);

    assert_clear_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FL_CLEAR) |=> !busy);
endmodule

// File: rtl/sfifo_thresh.sv
module sfifo_thresh #(
    parameter int CW       = 5,
    parameter int TW       = 4,
    parameter bit AT_LEAST = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          thr_wr,
    input  logic [TW-1:0] thr_data,
    input  logic [CW-1:0] level,
    output logic          hit
);
    logic [TW-1:0] thr;
    logic [CW-1:0] thr_ext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      thr <= '0;
        else if (thr_wr) thr <= thr_data;
    end

    assign thr_ext = CW'(thr);

    generate
        if (AT_LEAST) begin : g_ge
            assign hit = (level >= thr_ext);
        end else begin : g_le
            assign hit = (level <= thr_ext);
        end
    endgenerate
endmodule

// File: rtl/sfifo_pair.sv
module sfifo_pair
    import sfifo_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int FLUSH_CYCLES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctrl_wr,
    input  logic [8:0]              ctrl_wdata,
    output logic [8:0]              ctrl_rdata,
    input  logic                    thr_tx_wr,
    input  logic                    thr_rx_wr,
    input  logic [$clog2(DEPTH)-1:0] thr_wdata,
    input  logic                    host_tx_wr,
    input  logic [7:0]              host_tx_data,
    input  logic                    host_rx_rd,
    output logic [7:0]              host_rx_data,
    input  logic                    eng_tx_pop,
    output logic [7:0]              eng_tx_data,
    input  logic                    eng_rx_push,
    input  logic [7:0]              eng_rx_data,
    input  logic                    ovr_clr,
    output logic [$clog2(DEPTH):0]  tx_level,
    output logic [$clog2(DEPTH):0]  rx_level,
    output logic                    tx_empty,
    output logic                    tx_nearly_empty,
    output logic                    tx_full,
    output logic                    tx_overrun,
    output logic                    rx_empty,
    output logic                    rx_nearly_full,
    output logic                    rx_full
);
    localparam int TW = $clog2(DEPTH);
    localparam int CW = TW + 1;

    logic tx_busy, tx_clr, rx_busy, rx_clr;
    logic tx_start, rx_start;
    logic [7:0] tx_head, rx_head;
    logic ctrl_unused;

    assign ctrl_unused = ^ctrl_wdata[6:0];
    assign tx_start = ctrl_wr && ctrl_wdata[TX_FLUSH_BIT];
    assign rx_start = ctrl_wr && ctrl_wdata[RX_FLUSH_BIT];

    sfifo_flush_fsm #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_tx_flush (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .busy(tx_busy), .clr(tx_clr));

    sfifo_flush_fsm #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_rx_flush (
        .clk(clk), .rst_n(rst_n), .start(rx_start), .busy(rx_busy), .clr(rx_clr));

    sfifo_store #(.WIDTH(8), .DEPTH(DEPTH)) u_tx_store (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .wr_en(host_tx_wr && !tx_busy), .wr_data(host_tx_data),
        .rd_en(eng_tx_pop && !tx_busy), .rd_data(tx_head),
        .count(tx_level), .full(tx_full), .empty(tx_empty));

    sfifo_store #(.WIDTH(8), .DEPTH(DEPTH)) u_rx_store (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .wr_en(eng_rx_push && !rx_busy), .wr_data(eng_rx_data),
        .rd_en(host_rx_rd && !rx_busy), .rd_data(rx_head),
        .count(rx_level), .full(rx_full), .empty(rx_empty));

    sfifo_thresh #(.CW(CW), .TW(TW), .AT_LEAST(1'b0)) u_tx_thresh (
        .clk(clk), .rst_n(rst_n), .thr_wr(thr_tx_wr), .thr_data(thr_wdata),
        .level(tx_level), .hit(tx_nearly_empty));

    sfifo_thresh #(.CW(CW), .TW(TW), .AT_LEAST(1'b1)) u_rx_thresh (
        .clk(clk), .rst_n(rst_n), .thr_wr(thr_rx_wr), .thr_data(thr_wdata),
        .level(rx_level), .hit(rx_nearly_full));

    assign eng_tx_data  = tx_busy ? 8'h00 : tx_head;
    assign host_rx_data = rx_busy ? 8'h00 : rx_head;

    always_comb begin
        ctrl_rdata = '0;
        ctrl_rdata[TX_FLUSH_BIT] = tx_busy;
        ctrl_rdata[RX_FLUSH_BIT] = rx_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  tx_overrun <= 1'b0;
        else if (host_tx_wr && !tx_busy && tx_full)  tx_overrun <= 1'b1;
        else if (ovr_clr)                            tx_overrun <= 1'b0;
    end

    assert_tx_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> (tx_level == '0));

    assert_rx_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_busy) |-> (rx_level == '0));

    assert_no_ovr_in_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !ovr_clr) |=> $stable(tx_overrun));

    assert_overrun_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_overrun && !ovr_clr) |=> tx_overrun);

    assert_empty_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> (host_rx_data == 8'h00));

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty) && !(rx_full && rx_empty));
endmodule

// File: tb/sfifo_pair_test.sv
`timescale 1ns/1ps
module sfifo_pair_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [8:0] ctrl_wdata = '0;
    logic [8:0] ctrl_rdata;
    logic       thr_tx_wr = 1'b0, thr_rx_wr = 1'b0;
    logic [3:0] thr_wdata = '0;
    logic       host_tx_wr = 1'b0;
    logic [7:0] host_tx_data = '0;
    logic       host_rx_rd = 1'b0;
    logic [7:0] host_rx_data;
    logic       eng_tx_pop = 1'b0;
    logic [7:0] eng_tx_data;
    logic       eng_rx_push = 1'b0;
    logic [7:0] eng_rx_data = '0;
    logic       ovr_clr = 1'b0;
    logic [4:0] tx_level, rx_level;
    logic       tx_empty, tx_nearly_empty, tx_full, tx_overrun;
    logic       rx_empty, rx_nearly_full, rx_full;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sfifo_pair uut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .thr_tx_wr(thr_tx_wr), .thr_rx_wr(thr_rx_wr),
        .thr_wdata(thr_wdata), .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
        .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data), .eng_tx_pop(eng_tx_pop),
        .eng_tx_data(eng_tx_data), .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .ovr_clr(ovr_clr), .tx_level(tx_level), .rx_level(rx_level),
        .tx_empty(tx_empty), .tx_nearly_empty(tx_nearly_empty), .tx_full(tx_full),
        .tx_overrun(tx_overrun), .rx_empty(rx_empty), .rx_nearly_full(rx_nearly_full),
        .rx_full(rx_full));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] b);
        host_tx_wr = 1'b1; host_tx_data = b;
        @(negedge clk);
        host_tx_wr = 1'b0;
    endtask

    task automatic eng_push(input logic [7:0] b);
        eng_rx_push = 1'b1; eng_rx_data = b;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    task automatic host_read(input string tag, input logic [7:0] exp);
        chk(tag, host_rx_data, exp);
        host_rx_rd = 1'b1;
        @(negedge clk);
        host_rx_rd = 1'b0;
    endtask

    task automatic eng_pop(input string tag, input logic [7:0] exp);
        chk(tag, eng_tx_data, exp);
        eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    task automatic ctrl_write(input logic [8:0] v);
        ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_wr = 1'b0; ctrl_wdata = '0;
    endtask

    task automatic set_thr(input bit rx, input logic [3:0] v);
        thr_wdata = v;
        if (rx) thr_rx_wr = 1'b1; else thr_tx_wr = 1'b1;
        @(negedge clk);
        thr_tx_wr = 1'b0; thr_rx_wr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 tx_level", tx_level, 0);
        chk("R1 rx_level", rx_level, 0);
        chk("R1 empties", {tx_empty, rx_empty}, 2'b11);
        chk("R1 full/ovr", {tx_full, rx_full, tx_overrun}, 0);
        chk("R1 ctrl_rdata", ctrl_rdata, 0);
        chk("R1 data outs", {eng_tx_data, host_rx_data}, 0);
        chk("R1 thresh flags", {tx_nearly_empty, rx_nearly_full}, 2'b11);
    endtask

    task automatic t_order;
        for (int i = 0; i < 5; i++) begin
            host_write(8'hA0 + 8'(i));
            chk("R2 tx level step", tx_level, i + 1);
        end
        for (int i = 0; i < 5; i++) begin
            eng_pop("R2 tx order", 8'hA0 + 8'(i));
            chk("R2 tx level drain", tx_level, 4 - i);
        end
        for (int i = 0; i < 3; i++) eng_push(8'h60 + 8'(i));
        chk("R2 rx level", rx_level, 3);
        for (int i = 0; i < 3; i++) host_read("R2 rx order", 8'h60 + 8'(i));
        chk("R2 rx empty after", rx_empty, 1);
    endtask

    task automatic t_thresholds;
        set_thr(1'b0, 4'd3);
        set_thr(1'b1, 4'd2);
        for (int k = 1; k <= 5; k++) begin
            host_write(8'h40 + 8'(k));
            chk("R7 tx nearly empty", tx_nearly_empty, (k <= 3) ? 1 : 0);
        end
        for (int k = 1; k <= 5; k++) eng_pop("R7 drain", 8'h40 + 8'(k));
        chk("R7 at zero", tx_nearly_empty, 1);
        for (int k = 1; k <= 3; k++) begin
            eng_push(8'h50 + 8'(k));
            chk("R8 rx nearly full", rx_nearly_full, (k >= 2) ? 1 : 0);
        end
        for (int k = 1; k <= 3; k++) host_read("R8 drain", 8'h50 + 8'(k));
        set_thr(1'b1, 4'd15);
        for (int k = 1; k <= 16; k++) begin
            eng_push(8'h80 + 8'(k));
            if (k >= 14) chk("R8 thr 15", rx_nearly_full, (k >= 15) ? 1 : 0);
            if (k >= 15) chk("R9 rx full", rx_full, (k == 16) ? 1 : 0);
        end
        eng_push(8'hFF);
        chk("R9 rx push dropped level", rx_level, 16);
        for (int k = 1; k <= 16; k++) host_read("R9 rx intact", 8'h80 + 8'(k));
        chk("R9 rx empty", rx_empty, 1);
        set_thr(1'b0, 4'd0);
        set_thr(1'b1, 4'd0);
    endtask

    task automatic t_overrun;
        for (int i = 0; i < 16; i++) begin
            host_write(8'h10 + 8'(i));
            if (i == 14) chk("R9 not full at 15", tx_full, 0);
        end
        chk("R9 tx full", tx_full, 1);
        chk("R3 no ovr yet", tx_overrun, 0);
        host_write(8'hEE);
        chk("R3 level kept", tx_level, 16);
        chk("R3 ovr set", tx_overrun, 1);
        repeat (3) @(negedge clk);
        chk("R3 ovr sticky", tx_overrun, 1);
        for (int i = 0; i < 16; i++) eng_pop("R3 data intact", 8'h10 + 8'(i));
        chk("R9 tx empty", tx_empty, 1);
        chk("R3 ovr after drain", tx_overrun, 1);
        ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
        chk("R3 ovr cleared", tx_overrun, 0);
    endtask

    task automatic t_empty_access;
        host_read("R10 empty read zero", 8'h00);
        chk("R10 rx level stays", rx_level, 0);
        eng_pop("R10 empty pop zero", 8'h00);
        chk("R10 tx level stays", tx_level, 0);
        host_write(8'h55);
        eng_pop("R10 pointers intact", 8'h55);
        eng_push(8'h66);
        host_read("R10 rx pointers intact", 8'h66);
    endtask

    task automatic t_simul;
        host_write(8'h21);
        host_write(8'h22);
        host_tx_wr = 1'b1; host_tx_data = 8'h23; eng_tx_pop = 1'b1;
        @(negedge clk);
        host_tx_wr = 1'b0; eng_tx_pop = 1'b0;
        chk("R11 level kept", tx_level, 2);
        eng_pop("R11 order", 8'h22);
        eng_pop("R11 order", 8'h23);
    endtask

    task automatic t_flush_tx;
        for (int i = 0; i < 6; i++) host_write(8'h30 + 8'(i));
        for (int i = 0; i < 3; i++) eng_push(8'h70 + 8'(i));
        ctrl_write(9'h080);
        for (int k = 0; k < 4; k++) begin
            chk("R4 busy bit", ctrl_rdata, 9'h080);
            chk("R4 level held", tx_level, 6);
            @(negedge clk);
        end
        chk("R4 bit cleared", ctrl_rdata, 0);
        chk("R4 tx emptied", tx_level, 0);
        chk("R5 rx untouched", rx_level, 3);
        for (int i = 0; i < 3; i++) host_read("R5 rx data kept", 8'h70 + 8'(i));
    endtask

    task automatic t_flush_both;
        host_write(8'h01); host_write(8'h02);
        eng_push(8'h03); eng_push(8'h04);
        ctrl_write(9'h07F);
        chk("R5 no flush bits", ctrl_rdata, 0);
        chk("R5 no flush levels", {tx_level, rx_level}, {5'd2, 5'd2});
        ctrl_write(9'h100);
        chk("R5 rx only", ctrl_rdata, 9'h100);
        repeat (4) @(negedge clk);
        chk("R5 rx only result", {tx_level, rx_level}, {5'd2, 5'd0});
        eng_push(8'h05);
        ctrl_write(9'h180);
        chk("R5 both busy", ctrl_rdata, 9'h180);
        repeat (3) @(negedge clk);
        chk("R5 both still busy", ctrl_rdata, 9'h180);
        @(negedge clk);
        chk("R5 both done", ctrl_rdata, 0);
        chk("R5 both empty", {tx_empty, rx_empty}, 2'b11);
    endtask

    task automatic t_flush_ignore;
        for (int i = 0; i < 16; i++) host_write(8'hC0 + 8'(i));
        eng_push(8'h77);
        ctrl_write(9'h180);
        chk("R6 tx out zero", eng_tx_data, 0);
        chk("R6 rx out zero", host_rx_data, 0);
        host_tx_wr = 1'b1; host_tx_data = 8'hAB;
        eng_rx_push = 1'b1; eng_rx_data = 8'hCD;
        host_rx_rd = 1'b1; eng_tx_pop = 1'b1;
        repeat (4) @(negedge clk);
        host_tx_wr = 1'b0; eng_rx_push = 1'b0; host_rx_rd = 1'b0; eng_tx_pop = 1'b0;
        chk("R6 levels zero", {tx_level, rx_level}, 0);
        chk("R6 no overrun", tx_overrun, 0);
        chk("R6 idle", ctrl_rdata, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_order;
        t_thresholds;
        t_overrun;
        t_empty_access;
        t_simul;
        t_flush_tx;
        t_flush_both;
        t_flush_ignore;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule